// File: doc/BRIEF.md
# Serial SAR ADC Readout Controller

This block is the host-side master for a three-wire, 12-bit successive-approximation converter. The converter has an active-low select line that also controls its power-down, a serial clock driven by the host, and a serial data return. When the block receives a start request it pulls the select line low and derives the serial clock from the system clock through a divider. It lets the sample interval elapse, checks the leading null bit, and shifts in the data word most significant bit first.

Optionally the block keeps clocking after the last data bit and captures the least-significant-first echo of bits 1 to 11 that some converter variants send. It rebuilds those bits and compares them with the main word to catch transfer errors. At the end of the frame it drives select high again, which returns the converter to shutdown. It then reports the word and two error flags with a single-cycle strobe. Select is held high for a programmable minimum time before the next frame can begin.

Top module: `sar_adc_reader`

## Requirements
- R1: While reset is held and in the first cycle after it, `adcCsN` is 1, `adcSclk` is 0, `resultValid` is 0 and `busy` is 1.
- R2: A `start` seen while the block is idle drives `adcCsN` low at the next clock edge. The first rising edge of `adcSclk` follows exactly `HALF_DIV` system clocks later.
- R3: `adcSclk` is low whenever `adcCsN` is high. While a frame runs, `adcSclk` spends `HALF_DIV` system clocks high and `HALF_DIV` low in each period.
- R4: The bits sampled on rising edges 1 and 2 of a frame fall in the sample interval and have no effect on any result output.
- R5: The bit sampled on rising edge 3 is the null bit. `nullErr` is 1 in the result exactly when that bit was 1.
- R6: Rising edges 4 to 15 sample B11 down to B0. These bits appear in `resultData` with B11 at bit 11.
- R7: When `mirrorEn` was 0 at start, the frame has exactly 15 rising edges and `mirrorErr` is 0.
- R8: When `mirrorEn` was 1 at start, the frame has exactly 26 rising edges. Edges 16 to 26 sample B1 up to B11. `mirrorErr` is 1 exactly when any of those bits differs from the same bit of the main word.
- R9: `adcCsN` rises together with the last falling edge of `adcSclk`. One clock later `resultValid` is high for exactly one cycle with `resultData`, `nullErr` and `mirrorErr` valid.
- R10: `adcCsN` stays high for at least `GAP_CLKS` system clocks between frames and after reset. A `start` that arrives while a frame runs or during that gap is dropped, not queued.
- R11: `busy` is 0 exactly when a `start` would be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one conversion frame |
| mirrorEn | input | 1 | Capture and compare the LSB-first echo in this frame |
| busy | output | 1 | Frame or inter-frame gap in progress |
| adcCsN | output | 1 | Converter select, low during a frame, high for shutdown |
| adcSclk | output | 1 | Serial clock to the converter |
| adcSdo | input | 1 | Serial data from the converter |
| resultValid | output | 1 | One-cycle result strobe |
| resultData | output | 12 | Converted word |
| nullErr | output | 1 | Null bit was sampled high |
| mirrorErr | output | 1 | Echo bits disagreed with the main word |

## Verification
The converter model drives ones during the sample interval. A design that shifted those slots into the word would return corrupted upper bits. The rising-edge count per frame is checked in both modes, which exposes an off-by-one in the frame length that would drop B0 or a mirror bit. A corrupted echo, and a converter variant that sends zeros in place of the echo, are both used so that the comparison must both flag a mismatch and clear on a match. A start issued inside the inter-frame gap must be dropped: a design that queued or honoured it would pull select low too early.

// File: rtl/sar_rd_pkg.sv
package sar_rd_pkg;

  typedef enum logic [1:0] {
    SLOT_SAMPLE = 2'd0,
    SLOT_NULL   = 2'd1,
    SLOT_DATA   = 2'd2,
    SLOT_MIRROR = 2'd3
  } slot_e;

  typedef struct packed {
    logic  clear;
    logic  sample;
    slot_e slot;
    logic  finish;
    logic  checkMirror;
  } ctrlStrobe_t;

endpackage

// File: rtl/sar_rd_ctrl.sv
module sar_rd_ctrl
  import sar_rd_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int HALF_DIV = 50,
  parameter int GAP_CLKS = 200
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        mirrorEn,
  output logic        busy,
  output logic        csN,
  output logic        sclk,
  output ctrlStrobe_t stb
);

  localparam int LEAD_SLOTS   = 2;
  localparam int FRAME_EDGES  = LEAD_SLOTS + 1 + DATA_W;
  localparam int MIRROR_EDGES = FRAME_EDGES + DATA_W - 1;
  localparam int EDGE_W       = $clog2(MIRROR_EDGES + 1);
  localparam int DIV_W        = $clog2(HALF_DIV);
  localparam int GAP_W        = $clog2(GAP_CLKS + 1);

  typedef enum logic [1:0] {ST_GAP, ST_IDLE, ST_CLK, ST_FINISH} state_e;

  state_e             state;
  logic [DIV_W-1:0]   divCnt;
  logic [EDGE_W-1:0]  edgeCnt;
  logic [GAP_W-1:0]   gapCnt;
  logic               mirrorReg;
  logic               divDone;
  logic [EDGE_W-1:0]  lastEdge;

  assign divDone  = (divCnt == DIV_W'(HALF_DIV - 1));
  assign lastEdge = mirrorReg ? EDGE_W'(MIRROR_EDGES) : EDGE_W'(FRAME_EDGES);
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_GAP;
      divCnt    <= '0;
      edgeCnt   <= '0;
      gapCnt    <= '0;
      mirrorReg <= 1'b0;
      csN       <= 1'b1;
      sclk      <= 1'b0;
    end else begin
      case (state)
        ST_GAP: begin
          if (gapCnt == GAP_W'(GAP_CLKS - 1)) begin
            gapCnt <= '0;
            state  <= ST_IDLE;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        ST_IDLE: begin
          if (start) begin
            csN       <= 1'b0;
            mirrorReg <= mirrorEn;
            divCnt    <= '0;
            edgeCnt   <= '0;
            state     <= ST_CLK;
          end
        end
        ST_CLK: begin
          if (divDone) begin
            divCnt <= '0;
            sclk   <= ~sclk;
            if (!sclk) begin
              edgeCnt <= edgeCnt + 1'b1;
            end else if (edgeCnt == lastEdge) begin
              csN   <= 1'b1;
              state <= ST_FINISH;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_GAP;
      endcase
    end
  end

  always_comb begin
    stb.clear       = (state == ST_IDLE) && start;
    stb.sample      = (state == ST_CLK) && divDone && !sclk;
    stb.finish      = (state == ST_FINISH);
    stb.checkMirror = mirrorReg;
    if (edgeCnt < EDGE_W'(LEAD_SLOTS))        stb.slot = SLOT_SAMPLE;
    else if (edgeCnt == EDGE_W'(LEAD_SLOTS))  stb.slot = SLOT_NULL;
    else if (edgeCnt < EDGE_W'(FRAME_EDGES))  stb.slot = SLOT_DATA;
    else                                      stb.slot = SLOT_MIRROR;
  end

  // Checker state: cycles spent with select high, saturating.
  logic [15:0] highCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                 highCnt <= '0;
    else if (!csN)             highCnt <= '0;
    else if (highCnt != '1)    highCnt <= highCnt + 1'b1;
  end

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  p_sclk_steady_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CLK && !divDone) |=> $stable(sclk));

  p_start_cs_r2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && start) |=> !csN);

  p_gap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(csN)) |-> ($past(highCnt) >= 16'(GAP_CLKS)));

endmodule

// File: rtl/sar_rd_dp.sv
module sar_rd_dp
  import sar_rd_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sdo,
  input  ctrlStrobe_t       stb,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultData,
  output logic              nullErr,
  output logic              mirrorErr
);

  logic [DATA_W-1:0] dataSh;
  logic [DATA_W-2:0] mirSh;
  logic              nullSeen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataSh      <= '0;
      mirSh       <= '0;
      nullSeen    <= 1'b0;
      resultValid <= 1'b0;
      resultData  <= '0;
      nullErr     <= 1'b0;
      mirrorErr   <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      if (stb.clear) begin
        dataSh   <= '0;
        mirSh    <= '0;
        nullSeen <= 1'b0;
      end else if (stb.sample) begin
        case (stb.slot)
          SLOT_NULL:   nullSeen <= sdo;
          SLOT_DATA:   dataSh   <= {dataSh[DATA_W-2:0], sdo};
          SLOT_MIRROR: mirSh    <= {sdo, mirSh[DATA_W-2:1]};
          default:     ;
        endcase
      end
      if (stb.finish) begin
        resultValid <= 1'b1;
        resultData  <= dataSh;
        nullErr     <= nullSeen;
        mirrorErr   <= stb.checkMirror && (mirSh != dataSh[DATA_W-1:1]);
      end
    end
  end

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  p_mirror_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !$past(stb.checkMirror)) |-> !mirrorErr);

endmodule

// File: rtl/sar_adc_reader.sv
module sar_adc_reader
  import sar_rd_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int HALF_DIV = 50,
  parameter int GAP_CLKS = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              mirrorEn,
  output logic              busy,
  output logic              adcCsN,
  output logic              adcSclk,
  input  logic              adcSdo,
  output logic              resultValid,
  output logic [DATA_W-1:0] resultData,
  output logic              nullErr,
  output logic              mirrorErr
);

  ctrlStrobe_t stb;

  sar_rd_ctrl #(
    .DATA_W  (DATA_W),
    .HALF_DIV(HALF_DIV),
    .GAP_CLKS(GAP_CLKS)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .mirrorEn(mirrorEn),
    .busy    (busy),
    .csN     (adcCsN),
    .sclk    (adcSclk),
    .stb     (stb)
  );

  sar_rd_dp #(
    .DATA_W(DATA_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .sdo        (adcSdo),
    .stb        (stb),
    .resultValid(resultValid),
    .resultData (resultData),
    .nullErr    (nullErr),
    .mirrorErr  (mirrorErr)
  );

  p_valid_cs_high_r9: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (adcCsN && $past(adcCsN)));

endmodule

// File: tb/test_sar_adc_reader.sv
module test_sar_adc_reader;

  localparam int DATA_W   = 12;
  localparam int HALF_DIV = 3;
  localparam int GAP_CLKS = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic mirrorEn = 1'b0;
  logic busy, adcCsN, adcSclk, resultValid, nullErr, mirrorErr;
  logic [DATA_W-1:0] resultData;
  logic adcSdo = 1'b1;

  int testCnt = 0;
  int failCnt = 0;

  always #2.5 clk = ~clk;

  sar_adc_reader #(
    .DATA_W(DATA_W), .HALF_DIV(HALF_DIV), .GAP_CLKS(GAP_CLKS)
  ) i_sar_adc_reader (
    .clk(clk), .rstN(rstN), .start(start), .mirrorEn(mirrorEn),
    .busy(busy), .adcCsN(adcCsN), .adcSclk(adcSclk), .adcSdo(adcSdo),
    .resultValid(resultValid), .resultData(resultData),
    .nullErr(nullErr), .mirrorErr(mirrorErr)
  );

  // Converter model
  logic [DATA_W-1:0] modelWord = '0;
  logic modelNull = 1'b0;
  logic modelEcho = 1'b1;
  logic modelCorrupt = 1'b0;
  int   fallCnt = 0;
  int   riseCnt = 0;

  function automatic logic bitFor(int nf);
    if (nf < 2) return 1'b1;
    if (nf == 2) return modelNull;
    if (nf <= 14) return modelWord[14 - nf];
    if (nf <= 25) return modelEcho ? (modelWord[nf - 14] ^ (modelCorrupt && nf == 20)) : 1'b0;
    return 1'b0;
  endfunction

  always @(negedge adcCsN) begin fallCnt = 0; riseCnt = 0; adcSdo = 1'b1; end
  always @(posedge adcCsN) adcSdo = 1'b1;
  always @(posedge adcSclk) riseCnt = riseCnt + 1;
  always @(negedge adcSclk) begin
    if (!adcCsN) begin
      fallCnt = fallCnt + 1;
      #1 adcSdo = bitFor(fallCnt);
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic runFrame(input logic [DATA_W-1:0] w, input logic nullBad,
                          input logic mir, input logic echo, input logic corrupt,
                          input logic expMis);
    int guard = 0;
    waitIdle();
    modelWord = w; modelNull = nullBad; modelEcho = echo; modelCorrupt = corrupt;
    mirrorEn = mir; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(adcCsN == 1'b0, "R2", "select low after start", adcCsN, 0);
    while (!resultValid && guard < 1000) begin @(negedge clk); guard++; end
    check(resultData == w, "R6", "word (R4 sample slots ignored)", resultData, w);
    check(nullErr == nullBad, "R5", "null flag", nullErr, nullBad);
    check(mirrorErr == expMis, mir ? "R8" : "R7", "mirror flag", mirrorErr, expMis);
    check(riseCnt == (mir ? 26 : 15), mir ? "R8" : "R7", "rising edges", riseCnt, mir ? 26 : 15);
    check(adcCsN && !adcSclk, "R9", "select high at result", adcCsN, 1);
    @(negedge clk);
    check(!resultValid, "R9", "valid one cycle", resultValid, 0);
  endtask

  task automatic testReset();
    check(adcCsN && !adcSclk && !resultValid && busy, "R1", "reset outputs",
          {adcCsN, adcSclk, resultValid, busy}, 4'b1001);
  endtask

  task automatic testTiming();
    int lowCnt = 0;
    int highCnt = 0;
    waitIdle();
    modelWord = 12'h3C3; modelNull = 0; modelEcho = 1; modelCorrupt = 0;
    mirrorEn = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!adcSclk && lowCnt < 100) begin lowCnt++; @(negedge clk); end
    check(lowCnt == HALF_DIV, "R2", "select-to-first-rise clocks", lowCnt, HALF_DIV);
    while (adcSclk && highCnt < 100) begin highCnt++; @(negedge clk); end
    check(highCnt == HALF_DIV, "R3", "clock high time", highCnt, HALF_DIV);
    lowCnt = 0;
    while (!adcSclk && lowCnt < 100) begin lowCnt++; @(negedge clk); end
    check(lowCnt == HALF_DIV, "R3", "clock low time", lowCnt, HALF_DIV);
    while (!resultValid) @(negedge clk);
    check(resultData == 12'h3C3, "R6", "word", resultData, 12'h3C3);
  endtask

  task automatic testDroppedStart();
    bit early = 0;
    int gapCycles = 0;
    runFrame(12'h5A5, 0, 0, 1, 0, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < GAP_CLKS + 6; i++) begin
      if (!adcCsN) early = 1;
      if (adcSclk) early = 1;
      @(negedge clk);
    end
    check(!early, "R10", "start in gap dropped", early, 0);
    check(!busy, "R11", "idle after gap", busy, 0);
    // Measure the select-high time between two back-to-back frames.
    mirrorEn = 0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!resultValid) @(negedge clk);
    start = 1'b1;
    while (adcCsN && gapCycles < 1000) begin @(negedge clk); gapCycles++; end
    start = 1'b0;
    check(gapCycles >= GAP_CLKS, "R10", "select high between frames", gapCycles, GAP_CLKS);
    check(busy, "R11", "busy during frame", busy, 1);
    while (!resultValid) @(negedge clk);
  endtask

  initial begin
    #900us;
    failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTiming();
    runFrame(12'hA5C, 0, 0, 1, 0, 0);
    runFrame(12'h000, 0, 0, 1, 0, 0);
    runFrame(12'hFFF, 0, 0, 1, 0, 0);
    runFrame(12'h123, 1, 0, 1, 0, 0);
    runFrame(12'hB6D, 0, 1, 1, 0, 0);
    runFrame(12'hB6D, 0, 1, 1, 1, 1);
    runFrame(12'h001, 0, 1, 0, 0, 0);
    runFrame(12'h800, 0, 1, 0, 0, 1);
    runFrame(12'h7FE, 1, 1, 1, 0, 0);
    testDroppedStart();
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule